// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor. Code and data live in one external word memory, which the core reaches through a single synchronous port. Every instruction is brought in by an explicit fetch sequence. The program counter is copied into an address register, the counter steps, the memory word is captured in a data register, and that word is then moved into an instruction register for decoding. Execution works around a single accumulator, an address-wide index register and a one-bit compare flag.

Operands can be immediate, direct, indirect or indexed. The indirect and indexed forms spend extra memory cycles on address work. Character traffic uses two byte-wide handshake ports: an input the core waits on, and an output it strobes. The core stops for good on its end instruction or on an opcode it does not recognise, and a halted flag reports this. The reset input is asynchronous and active low, and its release is synchronised inside the core.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, halted, out_valid, mem_we and in_ready are low and mem_addr is 0. After reset, PC, ACC, IX and the compare flag are zero, and execution starts at address 0.
- R2: Each instruction word has the opcode in bits 15:12 and the operand in bits 11:0. The opcodes are 0 END, 1 LDM, 2 LDD, 3 LDI, 4 LDX, 5 LDR, 6 STO, 7 ADD, 8 INC, 9 CMP, 10 JPE, 11 JPN, 12 JMP, 13 IN, 14 OUT and 15 undefined. Counted from the third rising edge after reset release, an instruction takes 5 cycles, plus 3 for one data read, plus 6 for the two reads of LDI, plus 1 for STO, plus the input wait for IN.
- R3: LDM loads the zero-extended operand into ACC. LDR loads the operand into IX. INC adds one to ACC.
- R4: LDD loads the word at the operand address into ACC. ADD adds the word at the operand address to ACC, modulo 2^16.
- R5: LDI reads a pointer from the operand address, then loads ACC from the address held in the low 12 bits of that pointer.
- R6: LDX loads ACC from address (operand + IX) modulo 4096.
- R7: STO writes ACC to the operand address with mem_we high for exactly one cycle. No other instruction writes memory.
- R8: When operand bit 11 is 1, CMP compares ACC with the zero-extended literal in bits 10:0. When bit 11 is 0, it compares ACC with the word at address bits 10:0. The flag is set exactly when the two are equal.
- R9: JPE loads PC with the operand when the flag is 1. JPN does so when the flag is 0. JMP always does so. An untaken jump falls through to the next word.
- R10: IN raises in_ready and stalls until in_valid is high. It then loads ACC with the zero-extended in_data.
- R11: OUT raises out_valid for exactly one cycle, with out_data equal to ACC bits 7:0.
- R12: END or opcode 15 raises halted, which stays high until reset. While halted, no memory write and no output strobe occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address, taken from the address register |
| mem_wdata | output | 16 | Store data, taken from the data register |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| in_data | input | 8 | Input character code |
| in_valid | input | 1 | Input character present |
| in_ready | output | 1 | Core is waiting for an input character |
| out_data | output | 8 | Output character code |
| out_valid | output | 1 | One-cycle output strobe |
| halted | output | 1 | Core has stopped |

## Verification
The bench targets the cases where address work can slip. An LDI that skips its second read stores the pointer instead of the target word. An LDX that ignores IX picks a decoy word placed at the unindexed address. A count loop that ends on an immediate CMP and a JPN checks the flag path: a wrong flag or a wrong jump sense loops too often, or leaves the loop early, and the output byte sequence changes. A direct CMP that takes a JPE checks the memory-operand compare, and skipped stores must leave their cells at zero. A second program runs after a reset issued while IX and the flag are non-zero. Any state left over from the first program shows up as a wrong first output byte or a taken jump. That program ends on opcode 15, so a core that runs past an undefined opcode emits a stray byte. Every program also has its halt cycle checked against the per-instruction cycle costs, which exposes any extra or missing state.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  // Opcode values are fixed by the instruction encoding (R2)
  typedef enum logic [3:0] {
    OP_END = 4'd0,  OP_LDM = 4'd1,  OP_LDD = 4'd2,  OP_LDI = 4'd3,
    OP_LDX = 4'd4,  OP_LDR = 4'd5,  OP_STO = 4'd6,  OP_ADD = 4'd7,
    OP_INC = 4'd8,  OP_CMP = 4'd9,  OP_JPE = 4'd10, OP_JPN = 4'd11,
    OP_JMP = 4'd12, OP_IN  = 4'd13, OP_OUT = 4'd14, OP_BAD = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_WAIT, ST_F_MDR, ST_F_CIR, ST_DECODE,
    ST_D_WAIT, ST_D_MDR, ST_EXEC, ST_WRITE, ST_IN_WAIT, ST_HALT
  } state_e;

  typedef enum logic [1:0] {MAR_PC, MAR_OPND, MAR_INDEX, MAR_PTR} mar_src_e;

  typedef enum logic [2:0] {ACC_LIT, ACC_MEM, ACC_SUM, ACC_INC, ACC_CHAR} acc_src_e;

  typedef struct packed {
    logic     pc_inc;
    logic     pc_jump;
    logic     mar_en;
    mar_src_e mar_src;
    logic     mdr_mem;
    logic     mdr_acc;
    logic     cir_en;
    logic     acc_en;
    acc_src_e acc_src;
    logic     ix_en;
    logic     flag_en;
    logic     cmp_lit;
    logic     out_fire;
    logic     mem_we;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mdr,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] opnd,
  input  logic              cmp_lit,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] acc_inc,
  output logic              eq,
  output logic [ADDR_W-1:0] eff_idx
);
  localparam int LIT_W = ADDR_W - 1;

  logic [DATA_W-1:0] lit_ext;
  logic [DATA_W-1:0] cmp_rhs;

  always_comb begin
    lit_ext = {{(DATA_W-LIT_W){1'b0}}, opnd[LIT_W-1:0]};
    cmp_rhs = cmp_lit ? lit_ext : mdr;
    sum     = acc + mdr;
    acc_inc = acc + {{(DATA_W-1){1'b0}}, 1'b1};
    eq      = (acc == cmp_rhs);
    eff_idx = opnd + ix;
  end
endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  input  logic    imm_sel,
  input  logic    flag,
  input  logic    in_valid,
  output ctl_t    ctl,
  output logic    in_ready,
  output logic    halted
);
  state_e state, state_d;
  logic   ind_pend, ind_d;

  always_comb begin
    ctl         = '0;
    ctl.mar_src = MAR_PC;
    ctl.acc_src = ACC_LIT;
    state_d     = state;
    ind_d       = ind_pend;
    unique case (state)
      ST_F_ADDR: begin
        ctl.mar_en  = 1'b1;
        ctl.mar_src = MAR_PC;
        ctl.pc_inc  = 1'b1;
        state_d     = ST_F_WAIT;
      end
      ST_F_WAIT: state_d = ST_F_MDR;
      ST_F_MDR: begin
        ctl.mdr_mem = 1'b1;
        state_d     = ST_F_CIR;
      end
      ST_F_CIR: begin
        ctl.cir_en = 1'b1;
        state_d    = ST_DECODE;
      end
      ST_DECODE: begin
        state_d = ST_F_ADDR;
        unique case (op)
          OP_END, OP_BAD: state_d = ST_HALT;
          OP_LDM: begin ctl.acc_en = 1'b1; ctl.acc_src = ACC_LIT; end
          OP_LDR: ctl.ix_en = 1'b1;
          OP_INC: begin ctl.acc_en = 1'b1; ctl.acc_src = ACC_INC; end
          OP_LDD, OP_ADD: begin
            ctl.mar_en  = 1'b1;
            ctl.mar_src = MAR_OPND;
            state_d     = ST_D_WAIT;
          end
          OP_LDI: begin
            ctl.mar_en  = 1'b1;
            ctl.mar_src = MAR_OPND;
            ind_d       = 1'b1;
            state_d     = ST_D_WAIT;
          end
          OP_LDX: begin
            ctl.mar_en  = 1'b1;
            ctl.mar_src = MAR_INDEX;
            state_d     = ST_D_WAIT;
          end
          OP_CMP: begin
            if (imm_sel) begin
              ctl.flag_en = 1'b1;
              ctl.cmp_lit = 1'b1;
            end else begin
              ctl.mar_en  = 1'b1;
              ctl.mar_src = MAR_OPND;
              state_d     = ST_D_WAIT;
            end
          end
          OP_STO: begin
            ctl.mar_en  = 1'b1;
            ctl.mar_src = MAR_OPND;
            ctl.mdr_acc = 1'b1;
            state_d     = ST_WRITE;
          end
          OP_JPE: ctl.pc_jump = flag;
          OP_JPN: ctl.pc_jump = ~flag;
          OP_JMP: ctl.pc_jump = 1'b1;
          OP_IN:  state_d = ST_IN_WAIT;
          OP_OUT: ctl.out_fire = 1'b1;
          default: state_d = ST_HALT;
        endcase
      end
      ST_D_WAIT: state_d = ST_D_MDR;
      ST_D_MDR: begin
        ctl.mdr_mem = 1'b1;
        state_d     = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_F_ADDR;
        if (ind_pend) begin
          ctl.mar_en  = 1'b1;
          ctl.mar_src = MAR_PTR;
          ind_d       = 1'b0;
          state_d     = ST_D_WAIT;
        end else begin
          unique case (op)
            OP_LDD, OP_LDI, OP_LDX: begin
              ctl.acc_en = 1'b1; ctl.acc_src = ACC_MEM;
            end
            OP_ADD: begin ctl.acc_en = 1'b1; ctl.acc_src = ACC_SUM; end
            OP_CMP: ctl.flag_en = 1'b1;
            default: ;
          endcase
        end
      end
      ST_WRITE: begin
        ctl.mem_we = 1'b1;
        state_d    = ST_F_ADDR;
      end
      ST_IN_WAIT: begin
        if (in_valid) begin
          ctl.acc_en  = 1'b1;
          ctl.acc_src = ACC_CHAR;
          state_d     = ST_F_ADDR;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_F_ADDR;
      ind_pend <= 1'b0;
    end else begin
      state    <= state_d;
      ind_pend <= ind_d;
    end
  end

  assign in_ready = (state == ST_IN_WAIT);
  assign halted   = (state == ST_HALT);

  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R12
endmodule

// File: rtl/acc_cpu_regs.sv
`timescale 1ns/1ps
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CHAR_W-1:0] in_data,
  input  logic [DATA_W-1:0] sum,
  input  logic [DATA_W-1:0] acc_inc,
  input  logic              eq,
  input  logic [ADDR_W-1:0] eff_idx,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] cir,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] ix,
  output logic              flag,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid
);
  logic [ADDR_W-1:0] pc_d, mar_d, ix_d, opnd;
  logic [DATA_W-1:0] mdr_d, cir_d, acc_d;
  logic              flag_d, out_valid_d;
  logic [CHAR_W-1:0] out_data_d;

  assign opnd = cir[ADDR_W-1:0];

  always_comb begin
    pc_d = pc;
    if (ctl.pc_jump)     pc_d = opnd;
    else if (ctl.pc_inc) pc_d = pc + {{(ADDR_W-1){1'b0}}, 1'b1};

    mar_d = mar;
    if (ctl.mar_en) begin
      unique case (ctl.mar_src)
        MAR_PC:    mar_d = pc;
        MAR_OPND:  mar_d = opnd;
        MAR_INDEX: mar_d = eff_idx;
        MAR_PTR:   mar_d = mdr[ADDR_W-1:0];
        default:   mar_d = mar;
      endcase
    end

    mdr_d = mdr;
    if (ctl.mdr_mem)      mdr_d = mem_rdata;
    else if (ctl.mdr_acc) mdr_d = acc;

    cir_d = ctl.cir_en ? mdr : cir;

    acc_d = acc;
    if (ctl.acc_en) begin
      unique case (ctl.acc_src)
        ACC_LIT:  acc_d = {{(DATA_W-ADDR_W){1'b0}}, opnd};
        ACC_MEM:  acc_d = mdr;
        ACC_SUM:  acc_d = sum;
        ACC_INC:  acc_d = acc_inc;
        ACC_CHAR: acc_d = {{(DATA_W-CHAR_W){1'b0}}, in_data};
        default:  acc_d = acc;
      endcase
    end

    ix_d        = ctl.ix_en ? opnd : ix;
    flag_d      = ctl.flag_en ? eq : flag;
    out_valid_d = ctl.out_fire;
    out_data_d  = ctl.out_fire ? acc[CHAR_W-1:0] : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      mar       <= '0;
      mdr       <= '0;
      cir       <= '0;
      acc       <= '0;
      ix        <= '0;
      flag      <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      pc        <= pc_d;
      mar       <= mar_d;
      mdr       <= mdr_d;
      cir       <= cir_d;
      acc       <= acc_d;
      ix        <= ix_d;
      flag      <= flag_d;
      out_data  <= out_data_d;
      out_valid <= out_valid_d;
    end
  end

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !ctl.out_fire) |=> $stable(out_data)); // R11
endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int CHAR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   mem_we,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic [CHAR_W-1:0]      in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  output logic [CHAR_W-1:0]      out_data,
  output logic                   out_valid,
  output logic                   halted
);
  localparam int ADDR_W = DATA_W - OP_W;

  logic [1:0]        rst_pipe;
  logic              core_rst_n;
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc, mar, ix, eff_idx;
  logic [DATA_W-1:0] mdr, cir, acc, sum, acc_inc;
  logic              flag, eq;
  opcode_e           op;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign op = opcode_e'(cir[DATA_W-1 -: OP_W]);

  acc_cpu_seq seq_i (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .op       (op),
    .imm_sel  (cir[ADDR_W-1]),
    .flag     (flag),
    .in_valid (in_valid),
    .ctl      (ctl),
    .in_ready (in_ready),
    .halted   (halted)
  );

  acc_cpu_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) alu_i (
    .acc     (acc),
    .mdr     (mdr),
    .ix      (ix),
    .opnd    (cir[ADDR_W-1:0]),
    .cmp_lit (ctl.cmp_lit),
    .sum     (sum),
    .acc_inc (acc_inc),
    .eq      (eq),
    .eff_idx (eff_idx)
  );

  acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) regs_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .in_data   (in_data),
    .sum       (sum),
    .acc_inc   (acc_inc),
    .eq        (eq),
    .eff_idx   (eff_idx),
    .pc        (pc),
    .mar       (mar),
    .mdr       (mdr),
    .cir       (cir),
    .acc       (acc),
    .ix        (ix),
    .flag      (flag),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = ctl.mem_we;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we |=> !mem_we); // R7
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |-> (!mem_we && !out_valid)); // R12
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!core_rst_n)
    (halted && $past(halted)) |-> $stable(pc)); // R12
endmodule

// File: tb/acc_cpu_core_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_core_tb_top;
  localparam int STALL = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_data, out_data;
  logic        in_valid, in_ready, out_valid, halted;

  logic [15:0] mem [0:4095];
  logic [15:0] mm  [0:4095];

  int total = 0, bad = 0;
  int exp_out[$];
  int exp_wr[$];
  int chars[$];
  int in_q[$];

  always #2.5 clk = ~clk;

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int o);
    return {op[3:0], o[11:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = '0; end
  endtask

  task automatic put(input int a, input logic [15:0] w);
    mem[a] = w; mm[a] = w;
  endtask

  // Instruction-level reference: fills expectation queues, returns cycle cost
  task automatic run_model(output int cyc);
    logic [11:0] pc, o;
    logic [15:0] acc, w, p;
    logic [11:0] ix;
    bit          flag, done;
    int          ci;
    pc = '0; acc = '0; ix = '0; flag = 0; done = 0; cyc = 0; ci = 0;
    for (int s = 0; s < 2000 && !done; s++) begin
      w = mm[pc]; o = w[11:0]; pc = pc + 12'd1;
      cyc += 5;
      case (w[15:12])
        4'd1: acc = {4'b0, o};
        4'd2: begin acc = mm[o]; cyc += 3; end
        4'd3: begin p = mm[o]; acc = mm[p[11:0]]; cyc += 6; end
        4'd4: begin acc = mm[o + ix]; cyc += 3; end
        4'd5: ix = o;
        4'd6: begin mm[o] = acc; exp_wr.push_back({4'b0, o, acc}); cyc += 1; end
        4'd7: begin acc = acc + mm[o]; cyc += 3; end
        4'd8: acc = acc + 16'd1;
        4'd9: begin
          if (o[11]) flag = (acc == {5'b0, o[10:0]});
          else begin flag = (acc == mm[{1'b0, o[10:0]}]); cyc += 3; end
        end
        4'd10: if (flag) pc = o;
        4'd11: if (!flag) pc = o;
        4'd12: pc = o;
        4'd13: begin acc = {8'b0, chars[ci][7:0]}; ci++; cyc += STALL; end
        4'd14: exp_out.push_back(int'(acc[7:0]));
        default: done = 1;
      endcase
    end
  endtask

  // Reset, run until halt, compare every clock against the model
  task automatic run_prog(input string name);
    int  pred, n, wcnt, got;
    bit  seen;
    run_model(pred);
    in_q = chars;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!halted, "R1", {name, " halted in reset"}, int'(halted), 0);
    chk(!out_valid && !mem_we && !in_ready, "R1", {name, " strobes in reset"},
        int'({out_valid, mem_we, in_ready}), 0);
    chk(mem_addr == 12'd0, "R1", {name, " address in reset"}, int'(mem_addr), 0);
    rst_n = 1'b1;
    n = 0; wcnt = 0; seen = 0; got = 0;
    while (n < 3000 && got < 10) begin
      @(negedge clk); n++;
      if (mem_we) begin
        if (exp_wr.size() == 0)
          chk(0, "R7", {name, " unexpected write"}, int'({mem_addr, mem_wdata}), 0);
        else begin
          int e = exp_wr.pop_front();
          chk(int'({4'b0, mem_addr, mem_wdata}) == e, "R7", {name, " write addr/data"},
              int'({mem_addr, mem_wdata}), e);
        end
      end
      if (out_valid) begin
        if (exp_out.size() == 0)
          chk(0, "R11", {name, " unexpected output"}, int'(out_data), -1);
        else begin
          int e = exp_out.pop_front();
          chk(int'(out_data) == e, "R11", {name, " output byte"}, int'(out_data), e);
        end
      end
      if (halted && !seen) begin
        seen = 1;
        chk(n == pred + 2, "R2", {name, " halt cycle"}, n, pred + 2);
      end
      if (seen) got++;
      if (in_valid) begin
        in_valid = 1'b0; wcnt = 0;
      end else if (in_ready) begin
        wcnt++;
        if (wcnt == STALL && in_q.size() > 0) begin
          in_valid = 1'b1; in_data = in_q.pop_front()[7:0];
        end
      end
    end
    chk(seen, "R12", {name, " reached halt"}, int'(seen), 1);
    chk(halted, "R12", {name, " halt held"}, int'(halted), 1);
    chk(exp_out.size() == 0, "R11", {name, " missing outputs"}, exp_out.size(), 0);
    chk(exp_wr.size() == 0, "R7", {name, " missing writes"}, exp_wr.size(), 0);
  endtask

  task automatic expect_mem(input int a, input int v, input string req);
    chk(int'(mem[a]) == v, req, $sformatf("mem[%0h]", a), int'(mem[a]), v);
  endtask

  initial begin
    int mism;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    // Program A: every instruction kind plus a counting loop
    clear_mem();
    put('h00, ins(1, 5));      put('h01, ins(8, 0));      put('h02, ins(6, 'h200));
    put('h03, ins(2, 'h100));  put('h04, ins(7, 'h101));  put('h05, ins(6, 'h201));
    put('h06, ins(3, 'h102));  put('h07, ins(6, 'h202));  put('h08, ins(5, 2));
    put('h09, ins(4, 'h104));  put('h0A, ins(6, 'h203));  put('h0B, ins(1, 0));
    put('h0C, ins(8, 0));      put('h0D, ins(14, 0));     put('h0E, ins(9, 'h804));
    put('h0F, ins(11, 'h00C)); put('h10, ins(6, 'h204));  put('h11, ins(9, 'h105));
    put('h12, ins(10, 'h15));  put('h13, ins(1, 'hBAD));  put('h14, ins(6, 'h205));
    put('h15, ins(9, 'h100));  put('h16, ins(10, 'h19));  put('h17, ins(12, 'h1A));
    put('h18, ins(6, 'h205));  put('h19, ins(6, 'h206));  put('h1A, ins(1, 'hAA));
    put('h1B, ins(6, 'h207));  put('h1C, ins(13, 0));     put('h1D, ins(14, 0));
    put('h1E, ins(6, 'h208));  put('h1F, ins(13, 0));     put('h20, ins(14, 0));
    put('h21, ins(9, 'h869));  put('h22, ins(0, 0));      put('h23, ins(6, 'h209));
    put('h100, 16'h1234); put('h101, 16'h0011); put('h102, 16'h0103);
    put('h103, 16'hBEEF); put('h104, 16'h1111); put('h105, 16'h0004);
    put('h106, 16'h0777);
    chars = '{'h48, 'h69};
    run_prog("progA");
    expect_mem('h200, 'h0006, "R3");
    expect_mem('h201, 'h1245, "R4");
    expect_mem('h202, 'hBEEF, "R5");
    expect_mem('h203, 'h0777, "R6");
    expect_mem('h204, 'h0004, "R9");
    expect_mem('h205, 'h0000, "R9");
    expect_mem('h206, 'h0000, "R9");
    expect_mem('h207, 'h00AA, "R8");
    expect_mem('h208, 'h0048, "R10");
    expect_mem('h209, 'h0000, "R12");
    mism = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== mm[i]) mism++;
    chk(mism == 0, "R7", "image mismatches", mism, 0);

    // Program B after reset: ACC, IX and flag must start cleared
    clear_mem();
    put('h00, ins(14, 0)); put('h01, ins(10, 5)); put('h02, ins(4, 'h10));
    put('h03, ins(14, 0)); put('h04, 16'hF123);   put('h05, ins(14, 0));
    put('h06, ins(6, 'h20));
    put('h10, 16'h0033); put('h12, 16'h0044);
    chars = {};
    exp_out.delete(); exp_wr.delete();
    run_prog("progB");
    expect_mem('h20, 'h0000, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule